// File: doc/BRIEF.md
# Programmable Bit-Clock and Frame-Sync Generator

This block produces the serial bit clock and the periodic frame-sync pulse for an audio serial port. It divides either the local input clock or an external clock pin down to a bit clock. It then counts bit clocks to form a frame-sync pulse whose period and width are set independently, in bit clocks. Equal halves give a 50% duty left/right clock for I2S-style framing. A width of one bit clock gives a short DSP-style frame pulse.

All settings come from one 32-bit configuration word, loaded on a write strobe. Two level enables control the block. One runs the divider, and the other starts and stops frame-sync output. Both outputs can be inverted, so a downstream serial framer can use them directly. That framer can instead take its clock and sync from outside.

Top module: `bclk_fsync_gen`

## Requirements
- R1: The configuration word is loaded on a clock edge where `cfg_we_i` is high, and is left unchanged when it is low. Its fields are divider D in bits 7:0, pulse width W in bits 15:8, frame period P in bits 27:16, continuous mode in bit 28, internal source in bit 29 (1 = input clock, 0 = external pin), active-low frame sync in bit 30, and inverted bit clock in bit 31.
- R2: With D ≥ 1 and the generator enabled, the bit clock repeats every D+1 source ticks. It is active for floor((D+1)/2) ticks of each period.
- R3: With D = 0, the internal source selected and the generator enabled, `bclk_o` follows `clk_i`, or its inverse when bit 31 is set.
- R4: In continuous mode the frame-sync pulse repeats every P+1 bit clocks. Each pulse is active for W+1 bit clocks.
- R5: After frame-sync enable rises, the first pulse becomes active on the first bit-clock rising edge the block sees with the enable high. This takes at most D+1 input clocks, and the pulse starts in the same cycle as the bit clock's rise.
- R6: With bit 28 clear, each rise of the frame-sync enable yields exactly one pulse of W+1 bit clocks.
- R7: Bit 30 inverts `fsync_o` and bit 31 inverts `bclk_o`. The inversion applies to the idle levels too.
- R8: While `gen_en_i` is low, the bit clock holds its idle level from the next cycle, and frame sync stops. Once enabled, the first bit-clock rising edge comes on the first source tick.
- R9: While `fs_en_i` is low, `fsync_o` shows its inactive level from the next cycle.
- R10: With the external source, each rising edge of `ext_clk_i` counts as one source tick after a SYNC_STAGES-flop synchronizer. With D = 0, each tick gives a bit-clock pulse one input clock long.
- R11: After reset both outputs are low, and the configuration word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration word |
| gen_en_i | input | 1 | Runs the bit-clock divider |
| fs_en_i | input | 1 | Runs frame-sync output |
| ext_clk_i | input | 1 | External clock pin used as the alternative source |
| bclk_o | output | 1 | Bit clock |
| fsync_o | output | 1 | Frame sync |

## Verification
The bench measures the active time and the period of both outputs across divider settings, both odd and even, and across long and one-bit frame pulses. A divider that rounds the half period the wrong way, or a frame counter off by one, shows up directly in these measured cycle counts. It checks that the first frame pulse coincides with a bit-clock rise and arrives within one divider period. A design that started the frame on the enable itself, or one edge late, would fail that check. The remaining checks cover:
- that single-shot mode yields one pulse per enable rise and no second pulse;
- that disabling forces the inverted idle levels;
- that an ignored write leaves the divider unchanged;
- that the external source divides ticks rather than input clocks.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  localparam int DIV_W = 8;
  localparam int WID_W = 8;
  localparam int PER_W = 12;
  localparam int CFG_W = DIV_W + WID_W + PER_W + 4;

  // Field order sets the bit positions of the configuration word (MSB first).
  typedef struct packed {
    logic             ck_inv;   // 31: bit clock inverted
    logic             fs_low;   // 30: frame sync active low
    logic             int_src;  // 29: 1 = input clock, 0 = external pin
    logic             cont;     // 28: continuous frame sync
    logic [PER_W-1:0] per;      // 27:16 frame period - 1
    logic [WID_W-1:0] wid;      // 15:8  pulse width - 1
    logic [DIV_W-1:0] div;      // 7:0   divider - 1
  } cfg_t;
endpackage

// File: rtl/bfg_tick_src.sv
module bfg_tick_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic int_src_i,
  output logic tick_o
);
  localparam int SR_W = SYNC_STAGES + 1;

  logic [SR_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[SR_W-2:0], ext_clk_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  // One tick per synchronized rising edge, or every cycle on the input clock.
  assign tick_o = int_src_i | (sr_q[SR_W-2] & ~sr_q[SR_W-1]);
endmodule

// File: rtl/bfg_clk_div.sv
module bfg_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             bclk_q_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [DIV_W:0]   half;
  logic             bclk_q, bclk_d, wrap, zero_div;

  always_comb begin
    half     = ({1'b0, div_i} + 1'b1) >> 1;
    zero_div = (div_i == '0);
    wrap     = (cnt_q >= div_i);
    cnt_inc  = wrap ? '0 : cnt_q + 1'b1;
    cnt_d    = cnt_q;
    bclk_d   = bclk_q;
    rise_o   = 1'b0;
    if (!run_i) begin
      cnt_d  = div_i;           // first tick after enable wraps to zero
      bclk_d = 1'b0;
    end else if (tick_i) begin
      cnt_d  = cnt_inc;
      rise_o = (cnt_inc == '0);
      bclk_d = zero_div ? 1'b1 : ({1'b0, cnt_inc} < half);
    end else if (zero_div) begin
      bclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk_q_o = bclk_q;
endmodule

// File: rtl/bfg_frame_gen.sv
module bfg_frame_gen #(
  parameter int PER_W = 12,
  parameter int WID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             brise_i,
  input  logic             cont_i,
  input  logic [PER_W-1:0] per_i,
  input  logic [WID_W-1:0] wid_i,
  output logic             fs_q_o
);
  localparam int CW = (PER_W > WID_W) ? PER_W : WID_W;

  logic [PER_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             act_q, act_d, pend_q, pend_d, run_q, fs_q, fs_d;
  logic             start, wrap;
  logic [CW-1:0]    inc_x, wid_x;

  always_comb begin
    start   = run_i & ~run_q;
    wrap    = (cnt_q >= per_i);
    cnt_inc = wrap ? '0 : cnt_q + 1'b1;
    inc_x   = CW'(cnt_inc);
    wid_x   = CW'(wid_i);
    cnt_d   = cnt_q;
    act_d   = act_q;
    pend_d  = pend_q;
    fs_d    = fs_q;
    if (!run_i) begin
      cnt_d  = '0;
      act_d  = 1'b0;
      pend_d = 1'b0;
      fs_d   = 1'b0;
    end else begin
      pend_d = pend_q | start;
      if (brise_i) begin
        if (act_q) begin
          if (wrap && !cont_i) begin
            act_d = 1'b0;
            fs_d  = 1'b0;
          end else begin
            cnt_d = cnt_inc;
            fs_d  = (inc_x <= wid_x);
          end
        end else if (pend_q || start) begin
          act_d  = 1'b1;
          pend_d = 1'b0;
          cnt_d  = '0;
          fs_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      fs_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      run_q  <= run_i;
      fs_q   <= fs_d;
    end
  end

  assign fs_q_o = fs_q;
endmodule

// File: rtl/bclk_fsync_gen.sv
module bclk_fsync_gen
  import bfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             gen_en_i,
  input  logic             fs_en_i,
  input  logic             ext_clk_i,
  output logic             bclk_o,
  output logic             fsync_o
);
  cfg_t cfg_q, cfg_d;
  logic tick, brise, bclk_q, fs_q, pass_clk, bclk_raw;

  always_comb begin
    cfg_d = cfg_we_i ? cfg_t'(cfg_wdata_i) : cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  bfg_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_clk_i(ext_clk_i),
    .int_src_i(cfg_q.int_src),
    .tick_o   (tick)
  );

  bfg_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (gen_en_i),
    .tick_i  (tick),
    .div_i   (cfg_q.div),
    .bclk_q_o(bclk_q),
    .rise_o  (brise)
  );

  bfg_frame_gen #(.PER_W(PER_W), .WID_W(WID_W)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (gen_en_i & fs_en_i),
    .brise_i(brise),
    .cont_i (cfg_q.cont),
    .per_i  (cfg_q.per),
    .wid_i  (cfg_q.wid),
    .fs_q_o (fs_q)
  );

  // Divide-by-one on the input clock passes the clock itself through.
  assign pass_clk = cfg_q.int_src & (cfg_q.div == '0) & gen_en_i;
  assign bclk_raw = pass_clk ? clk_i : bclk_q;
  assign bclk_o   = bclk_raw ^ cfg_q.ck_inv;
  assign fsync_o  = fs_q ^ cfg_q.fs_low;
endmodule

// File: rtl/bfg_checker.sv
module bfg_checker
  import bfg_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic gen_en_i,
  input logic fs_en_i,
  input logic fsync_o,
  input cfg_t cfg_q,
  input logic bclk_q,
  input logic fs_q
);
  a_r9_fsync_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_en_i |=> (fsync_o == cfg_q.fs_low));

  a_r8_bclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_en_i |=> !bclk_q);

  a_r5_frame_on_bit_rise: assert property (@(posedge clk_i)
    disable iff (!rst_ni || cfg_q.div == '0)
    $rose(fs_q) |-> $rose(bclk_q));

  a_r9_fs_needs_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> $past(fs_en_i && gen_en_i));

  a_r8_bclk_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_q |-> $past(gen_en_i));
endmodule

bind bclk_fsync_gen bfg_checker u_bfg_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .gen_en_i(gen_en_i),
  .fs_en_i (fs_en_i),
  .fsync_o (fsync_o),
  .cfg_q   (cfg_q),
  .bclk_q  (bclk_q),
  .fs_q    (fs_q)
);

// File: tb/bclk_fsync_gen_bench.sv
module bclk_fsync_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        gen_en = 1'b0;
  logic        fs_en = 1'b0;
  logic        ext_clk = 1'b0;
  logic        bclk, fsync;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit cur_inv = 1'b0;
  bit cur_fsl = 1'b0;

  always #5 clk = ~clk;

  bclk_fsync_gen u_bclk_fsync_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .gen_en_i(gen_en), .fs_en_i(fs_en), .ext_clk_i(ext_clk),
    .bclk_o(bclk), .fsync_o(fsync)
  );

  // Table: divider, width, period, fsync active low, bit clock inverted.
  localparam int NV = 4;
  localparam int VEC [NV][5] = '{
    '{3, 15, 31, 0, 0},
    '{1,  0,  7, 0, 0},
    '{4,  2,  5, 1, 0},
    '{2,  1,  3, 0, 1}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int d, int w, int p, bit cont, bit isrc, bit fsl, bit ck);
    logic [7:0] d8 = 8'(d);
    logic [7:0] w8 = 8'(w);
    logic [11:0] p12 = 12'(p);
    return {ck, fsl, isrc, cont, p12, w8, d8};
  endfunction

  function automatic bit bact();
    return bclk ^ cur_inv;
  endfunction

  function automatic bit fact();
    return fsync ^ cur_fsl;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] w, input bit we);
    step();
    cfg_we = we; cfg_wdata = w;
    step();
    cfg_we = 1'b0;
    if (we) begin cur_inv = w[31]; cur_fsl = w[30]; end
  endtask

  // Measures active samples and samples between two rises (0 = bit clock, 1 = frame sync).
  task automatic run_len(input bit which, output int hi, output int per);
    bit p, s;
    hi = 0; per = 0;
    p = which ? fact() : bact();
    for (int k = 0; k < 5000; k++) begin
      step();
      s = which ? fact() : bact();
      if (!p && s) break;
      p = s;
    end
    for (int k = 0; k < 5000; k++) begin
      s = which ? fact() : bact();
      if (s) hi++;
      per++;
      p = s;
      step();
      s = which ? fact() : bact();
      if (!p && s) break;
    end
  endtask

  initial begin
    int hi, per, n, rises, act;
    bit pb, pf;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11: reset state
    check(bclk == 1'b0 && fsync == 1'b0, "R11 reset outputs", {bclk, fsync}, 0);

    for (int v = 0; v < NV; v++) begin
      int d = VEC[v][0], w = VEC[v][1], p = VEC[v][2];
      gen_en = 1'b0; fs_en = 1'b0;
      write_cfg(mk(d, w, p, 1'b1, 1'b1, VEC[v][3] != 0, VEC[v][4] != 0), 1'b1);
      step();
      // R7: idle levels follow the inversion bits
      check(bclk == cur_inv, "R7 bclk idle level", bclk, cur_inv);
      check(fsync == cur_fsl, "R7 fsync idle level", fsync, cur_fsl);
      gen_en = 1'b1;
      run_len(1'b0, hi, per);
      check(per == d + 1, "R2 R1 bclk period", per, d + 1);
      check(hi == (d + 1) / 2, "R2 bclk active time", hi, (d + 1) / 2);
      step();
      fs_en = 1'b1;
      n = 0; pb = bact();
      for (int k = 0; k < 100; k++) begin
        step(); n++;
        if (fact()) break;
        pb = bact();
      end
      check(n <= d + 1, "R5 first pulse latency", n, d + 1);
      check(bact() && !pb, "R5 pulse starts with bclk rise", {pb, bact()}, 1);
      run_len(1'b1, hi, per);
      check(hi == (w + 1) * (d + 1), "R4 R1 pulse width", hi, (w + 1) * (d + 1));
      check(per == (p + 1) * (d + 1), "R4 R1 frame period", per, (p + 1) * (d + 1));
      // R9: disabling frame sync mid-pulse
      for (int k = 0; k < 200 && !fact(); k++) step();
      fs_en = 1'b0;
      step();
      check(fact() == 1'b0, "R9 fsync inactive after disable", fsync, cur_fsl);
      gen_en = 1'b0;
      step();
      check(bclk == cur_inv, "R8 bclk idle after disable", bclk, cur_inv);
    end

    // R3: divide by one on the input clock
    write_cfg(mk(0, 0, 3, 1'b1, 1'b1, 1'b0, 1'b0), 1'b1);
    gen_en = 1'b1;
    step();
    @(posedge clk); #1;
    check(bclk == 1'b1, "R3 bclk high with clk high", bclk, 1);
    @(negedge clk); #1;
    check(bclk == 1'b0, "R3 bclk low with clk low", bclk, 0);
    write_cfg(mk(0, 0, 3, 1'b1, 1'b1, 1'b0, 1'b1), 1'b1);
    @(posedge clk); #1;
    check(bclk == 1'b0, "R3 R7 inverted passthrough", bclk, 0);
    gen_en = 1'b0;

    // R6: single-shot frame sync
    write_cfg(mk(1, 2, 5, 1'b0, 1'b1, 1'b0, 1'b0), 1'b1);
    gen_en = 1'b1;
    repeat (4) step();
    for (int r = 0; r < 2; r++) begin
      fs_en = 1'b1;
      rises = 0; act = 0; pf = fact();
      for (int k = 0; k < 60; k++) begin
        step();
        if (fact()) act++;
        if (fact() && !pf) rises++;
        pf = fact();
      end
      check(rises == 1, "R6 one pulse per enable rise", rises, 1);
      check(act == 6, "R6 single pulse width", act, 6);
      fs_en = 1'b0;
      step();
    end
    gen_en = 1'b0;

    // R10: external source, 8-cycle ext clock
    fork
      begin
        for (int k = 0; k < 120; k++) begin
          #40 ext_clk = ~ext_clk;
        end
      end
    join_none
    write_cfg(mk(1, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0), 1'b1);
    gen_en = 1'b1;
    run_len(1'b0, hi, per);
    check(per == 16, "R10 ext bclk period", per, 16);
    check(hi == 8, "R10 ext bclk active time", hi, 8);
    // R1: a write with the strobe low is ignored
    write_cfg(mk(3, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0), 1'b0);
    run_len(1'b0, hi, per);
    check(per == 16, "R1 ignored write keeps divider", per, 16);
    write_cfg(mk(0, 0, 3, 1'b1, 1'b0, 1'b0, 1'b0), 1'b1);
    run_len(1'b0, hi, per);
    check(per == 8, "R10 ext divide-by-one period", per, 8);
    check(hi == 1, "R10 ext divide-by-one pulse", hi, 1);
    gen_en = 1'b0;
    step();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule